// File: doc/BRIEF.md
# Bit-Serial 16-Bit ALU with Shared Status Flag

This block is the arithmetic core of a minimal serial processor. Operand words arrive one bit per clock, least significant bit first: a primary operand on one serial line (normally read out of data memory) and an optional secondary operand on another line. The result leaves on a serial line, also least significant bit first, ready to be written back to memory. All of the computation goes through a one-bit slice that holds one carry bit from step to step.

A single status flag serves every operation. Additions, subtractions, increments and decrements leave carry or borrow in it. Shifts and rotates leave the bit that was pushed out. Logic operations, complement and negate leave a zero indication. Dedicated codes set or clear the flag directly. Add-with-carry, subtract-with-borrow and the rotates read the flag as an input.

An operation starts with a one-cycle `start` pulse that also carries operand bit 0. The block gathers the remaining operand bits in a staging register, because right shifts and bit reversal need higher bits before lower ones. It then runs the one-bit slice over the word and streams the result out.

Top module: `bitser_alu`

## Requirements
- R1: The opcode is a 5-bit code: ADD=0, ADC=1, SUB=2, SBC=3, INC=4, DEC=5, AND=6, OR=7, XOR=8, COM=9, NEG=10, LSL=11, LSR=12, ROL=13, ROR=14, ASR=15, REV=16, SETF=17, CLRF=18. Codes 19 to 31 copy A and leave the flag alone.
- R1 (timing): `start` is sampled together with A/B bit 0 at clock edge 0, and bit k is sampled at edge k. Result bit i is on `res_bit`, with `res_valid` high, after edge 16+i. `res_valid` is low again and `busy` is low after edge 32. The final flag is visible after edge 31.
- R2: ADD gives A+B and ADC gives A+B+flag. The flag becomes the carry out of bit 15.
- R3: SUB gives A−B and SBC gives A−B−flag. The flag becomes 1 when a borrow occurred, that is, when the true difference is negative.
- R4: INC gives A+1 and leaves 1 in the flag only when A was 0xFFFF. DEC gives A−1 and leaves 1 in the flag only when A was 0.
- R5: AND, OR and XOR with B, COM (~A) and NEG (−A, two's complement) set the flag to 1 exactly when the 16-bit result is zero.
- R6: LSL and LSR shift by one with a zero fill. The flag gets the bit shifted out: A[15] for LSL and A[0] for LSR.
- R7: ROL fills bit 0 with the old flag and ROR fills bit 15 with the old flag. The flag then takes the bit shifted out.
- R8: ASR shifts right, keeps bit 15 unchanged, and puts A[0] in the flag.
- R9: REV returns A with its bit order reversed, and the undefined codes return A. Neither changes the flag.
- R10: SETF and CLRF, accepted while idle, set or clear the flag after that one edge. They do not raise `busy` or `res_valid`.
- R11: While `busy`, `start` and `op` are ignored. Even a SETF/CLRF request held during an operation changes neither that operation's result nor its flag.
- R12: After reset the flag is 0, and `res_valid`, `res_bit` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins an operation; marks operand bit 0 |
| op | input | 5 | Operation code (see R1) |
| a_bit | input | 1 | Serial primary operand, LSB first |
| b_bit | input | 1 | Serial secondary operand, LSB first |
| res_bit | output | 1 | Serial result, LSB first |
| res_valid | output | 1 | Qualifies res_bit |
| flag | output | 1 | Carry/borrow/shifted-out or zero status |
| busy | output | 1 | Operation in progress |

## Verification
The hard cases are the ones where the flag feeds an operation: ADC, SBC, ROL and ROR. Each depends on a flag value left behind by an earlier operation, and that value is awkward to predict at the ports. The bench therefore sets the flag to a chosen value with SETF or CLRF before every operation. It sweeps both flag values across a grid of edge-case words, so carry and borrow chains run through all 16 bits. A second hard case is a request arriving in the middle of an operation. The bench holds `start` high with a flag opcode for the whole gathering phase and then checks that the running result and flag are untouched.

// File: rtl/bitser_pkg.sv
package bitser_pkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_INC  = 5'd4,
    OP_DEC  = 5'd5,
    OP_AND  = 5'd6,
    OP_OR   = 5'd7,
    OP_XOR  = 5'd8,
    OP_COM  = 5'd9,
    OP_NEG  = 5'd10,
    OP_LSL  = 5'd11,
    OP_LSR  = 5'd12,
    OP_ROL  = 5'd13,
    OP_ROR  = 5'd14,
    OP_ASR  = 5'd15,
    OP_REV  = 5'd16,
    OP_SETF = 5'd17,
    OP_CLRF = 5'd18
  } alu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_e;

  // one-bit full adder, sum half
  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  // one-bit full adder, carry half
  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (c & (x ^ y));
  endfunction

  // carry loaded into the slice before bit 0
  function automatic logic carry_seed(input alu_op_e op, input logic f);
    case (op)
      OP_ADC:                    return f;
      OP_SBC:                    return ~f;
      OP_SUB, OP_INC, OP_NEG:    return 1'b1;
      default:                   return 1'b0;
    endcase
  endfunction

  function automatic logic is_flag_op(input alu_op_e op);
    return (op == OP_SETF) || (op == OP_CLRF);
  endfunction

endpackage

// File: rtl/bitser_stage.sv
// Operand staging: NSRC serial lines, each gathered into a W-bit word,
// bit 0 first (shifted in at the top, so bit 0 ends at index 0).
module bitser_stage #(
  parameter int W    = 16,
  parameter int NSRC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift_en,
  input  logic [NSRC-1:0]          din,
  output logic [NSRC-1:0][W-1:0]   word
);
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        word[s] <= '0;
      else if (shift_en) word[s] <= {din[s], word[s][W-1:1]};
    end
  end
endmodule

// File: rtl/bitser_seq.sv
// Phase sequencer: idle -> gather W bits -> run W slice steps -> idle.
module bitser_seq
  import bitser_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          flag_req,
  output logic          accept,
  output logic          load_en,
  output logic          run_begin,
  output logic          run_step,
  output logic          last_step,
  output logic          busy,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LASTIDX = CW'(W - 1);

  seq_state_e state;

  assign accept    = (state == ST_IDLE) && start && !flag_req;
  assign load_en   = accept || (state == ST_LOAD);
  assign run_begin = (state == ST_LOAD) && (cnt == LASTIDX);
  assign run_step  = (state == ST_RUN);
  assign last_step = run_step && (cnt == LASTIDX);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state <= ST_LOAD;
          cnt   <= CW'(1);
        end
        ST_LOAD: if (cnt == LASTIDX) begin
          state <= ST_RUN;
          cnt   <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
        ST_RUN: if (cnt == LASTIDX) begin
          state <= ST_IDLE;
          cnt   <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/bitser_slice.sv
// One-bit ALU slice: result bit, next carry and the flag value this
// step would leave if it is the final one.
module bitser_slice
  import bitser_pkg::*;
(
  input  alu_op_e op,
  input  logic    first,
  input  logic    last,
  input  logic    a_here,
  input  logic    a_lo,
  input  logic    a_hi,
  input  logic    a_rev,
  input  logic    a_msb,
  input  logic    a_lsb,
  input  logic    b_here,
  input  logic    carry,
  input  logic    zacc,
  input  logic    flag_cur,
  output logic    r,
  output logic    carry_nx,
  output logic    flag_nx
);
  logic x, y, sum;

  always_comb begin
    x = a_here;
    y = 1'b0;
    case (op)
      OP_ADD, OP_ADC: y = b_here;
      OP_SUB, OP_SBC: y = ~b_here;
      OP_DEC:         y = 1'b1;
      OP_NEG:         x = ~a_here;
      default:        y = 1'b0;
    endcase
    sum      = fa_sum(x, y, carry);
    carry_nx = fa_carry(x, y, carry);
  end

  always_comb begin
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC,
      OP_INC, OP_DEC, OP_NEG: r = sum;
      OP_AND: r = a_here & b_here;
      OP_OR:  r = a_here | b_here;
      OP_XOR: r = a_here ^ b_here;
      OP_COM: r = ~a_here;
      OP_LSL: r = first ? 1'b0 : a_lo;
      OP_ROL: r = first ? flag_cur : a_lo;
      OP_LSR: r = last ? 1'b0 : a_hi;
      OP_ROR: r = last ? flag_cur : a_hi;
      OP_ASR: r = last ? a_here : a_hi;
      OP_REV: r = a_rev;
      default: r = a_here;
    endcase
  end

  always_comb begin
    case (op)
      OP_ADD, OP_ADC, OP_INC:  flag_nx = carry_nx;
      OP_SUB, OP_SBC, OP_DEC:  flag_nx = ~carry_nx;
      OP_AND, OP_OR, OP_XOR,
      OP_COM, OP_NEG:          flag_nx = zacc & ~r;
      OP_LSL, OP_ROL:          flag_nx = a_msb;
      OP_LSR, OP_ROR, OP_ASR:  flag_nx = a_lsb;
      default:                 flag_nx = flag_cur;
    endcase
  end
endmodule

// File: rtl/bitser_alu.sv
module bitser_alu
  import bitser_pkg::*;
#(
  parameter int W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [4:0] op,
  input  logic       a_bit,
  input  logic       b_bit,
  output logic       res_bit,
  output logic       res_valid,
  output logic       flag,
  output logic       busy
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LASTIDX = CW'(W - 1);

  alu_op_e op_in, op_q;
  assign op_in = alu_op_e'(op);

  logic          accept, load_en, run_begin, run_step, last_step;
  logic [CW-1:0] cnt;
  logic          flag_req;
  assign flag_req = is_flag_op(op_in);

  bitser_seq #(.W(W), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .flag_req(flag_req),
    .accept(accept), .load_en(load_en), .run_begin(run_begin),
    .run_step(run_step), .last_step(last_step), .busy(busy), .cnt(cnt)
  );

  logic [1:0][W-1:0] words;
  logic [W-1:0]      a_w, b_w;

  bitser_stage #(.W(W), .NSRC(2)) u_stage (
    .clk(clk), .rst_n(rst_n), .shift_en(load_en),
    .din({b_bit, a_bit}), .word(words)
  );
  assign a_w = words[0];
  assign b_w = words[1];

  // operand taps for the current step
  logic first, a_here, a_lo, a_hi, a_rev, b_here;
  assign first  = (cnt == '0);
  assign a_here = a_w[cnt];
  assign a_lo   = first ? 1'b0 : a_w[cnt - CW'(1)];
  assign a_hi   = (cnt == LASTIDX) ? 1'b0 : a_w[cnt + CW'(1)];
  assign a_rev  = a_w[LASTIDX - cnt];
  assign b_here = b_w[cnt];

  logic carry, zacc, slice_r, carry_nx, flag_nx;

  bitser_slice u_slice (
    .op(op_q), .first(first), .last(cnt == LASTIDX),
    .a_here(a_here), .a_lo(a_lo), .a_hi(a_hi), .a_rev(a_rev),
    .a_msb(a_w[W-1]), .a_lsb(a_w[0]), .b_here(b_here),
    .carry(carry), .zacc(zacc), .flag_cur(flag),
    .r(slice_r), .carry_nx(carry_nx), .flag_nx(flag_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q      <= OP_ADD;
      carry     <= 1'b0;
      zacc      <= 1'b1;
      flag      <= 1'b0;
      res_bit   <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      if (accept) op_q <= op_in;

      if (run_begin) begin
        carry <= carry_seed(op_q, flag);
        zacc  <= 1'b1;
      end else if (run_step) begin
        carry <= carry_nx;
        zacc  <= zacc & ~slice_r;
      end

      if (!busy && start && op_in == OP_SETF)      flag <= 1'b1;
      else if (!busy && start && op_in == OP_CLRF) flag <= 1'b0;
      else if (last_step)                          flag <= flag_nx;

      res_bit   <= run_step ? slice_r : 1'b0;
      res_valid <= run_step;
    end
  end
endmodule

// File: rtl/bitser_alu_chk.sv
module bitser_alu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [4:0] op,
  input logic [4:0] op_q,
  input logic       busy,
  input logic       flag,
  input logic       res_valid,
  input logic       run_step,
  input logic       last_step
);
  // R1: every slice step yields one qualified output bit
  p_step_gives_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run_step |=> res_valid);
  p_bit_needs_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(run_step));
  // R10: explicit flag operations
  p_setf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && op == 5'd17) |=> (flag && !busy));
  p_clrf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && op == 5'd18) |=> (!flag && !busy));
  // R11: mid-operation the flag is frozen and the operation keeps going
  p_flag_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> $stable(flag));
  p_busy_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> busy);
  // R9: bit reverse leaves the flag alone
  p_rev_keeps_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (last_step && op_q == 5'd16) |=> $stable(flag));
endmodule

bind bitser_alu bitser_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .op_q(op_q),
  .busy(busy), .flag(flag), .res_valid(res_valid),
  .run_step(run_step), .last_step(last_step)
);

// File: tb/bitser_alu_test.sv
module bitser_alu_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [4:0] op = 5'd0;
  logic       a_bit = 1'b0, b_bit = 1'b0;
  logic       res_bit, res_valid, flag, busy;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;  // 125 MHz

  bitser_alu uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .a_bit(a_bit),
    .b_bit(b_bit), .res_bit(res_bit), .res_valid(res_valid),
    .flag(flag), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int got, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic string req_of(input int code);
    case (code)
      0, 1:            return "R2";
      2, 3:            return "R3";
      4, 5:            return "R4";
      6, 7, 8, 9, 10:  return "R5";
      11, 12:          return "R6";
      13, 14:          return "R7";
      15:              return "R8";
      default:         return "R9";
    endcase
  endfunction

  // reference: {flag, result}
  function automatic logic [16:0] model(input int code, input logic [15:0] a,
                                        input logic [15:0] b, input logic fin);
    logic [15:0] r;
    logic        f;
    int          ia, ib, ic, t;
    ia = int'(a); ib = int'(b); ic = fin ? 1 : 0;
    r = a; f = fin;
    case (code)
      0:  begin t = ia + ib;      r = t[15:0]; f = (t > 65535); end
      1:  begin t = ia + ib + ic; r = t[15:0]; f = (t > 65535); end
      2:  begin t = ia - ib;      r = t[15:0]; f = (t < 0); end
      3:  begin t = ia - ib - ic; r = t[15:0]; f = (t < 0); end
      4:  begin t = ia + 1;       r = t[15:0]; f = (ia == 65535); end
      5:  begin t = ia - 1;       r = t[15:0]; f = (ia == 0); end
      6:  begin r = a & b; f = (r == 16'd0); end
      7:  begin r = a | b; f = (r == 16'd0); end
      8:  begin r = a ^ b; f = (r == 16'd0); end
      9:  begin r = ~a;    f = (r == 16'd0); end
      10: begin t = 65536 - ia; r = t[15:0]; f = (r == 16'd0); end
      11: begin r = {a[14:0], 1'b0}; f = a[15]; end
      12: begin r = {1'b0, a[15:1]}; f = a[0]; end
      13: begin r = {a[14:0], fin};  f = a[15]; end
      14: begin r = {fin, a[15:1]};  f = a[0]; end
      15: begin r = {a[15], a[15:1]}; f = a[0]; end
      16: for (int k = 0; k < 16; k++) r[k] = a[15-k];
      default: r = a;
    endcase
    return {f, r};
  endfunction

  task automatic flag_op(input bit setit);
    @(negedge clk);
    start = 1'b1; op = setit ? 5'd17 : 5'd18;
    @(negedge clk);
    start = 1'b0;
    check(flag == setit && !busy && !res_valid, "R10", "flag op",
          int'(flag), int'(setit));
  endtask

  task automatic run_op(input int code, input logic [15:0] a,
                        input logic [15:0] b, input logic fin, input bit noisy);
    logic [15:0] got;
    logic [16:0] exp;
    bit          vld_ok;
    string       tag;
    flag_op(fin);
    exp = model(code, a, b, fin);
    tag = noisy ? "R11" : req_of(code);
    @(negedge clk);
    start = 1'b1; op = 5'(code); a_bit = a[0]; b_bit = b[0];
    for (int k = 1; k < 16; k++) begin
      @(negedge clk);
      start = noisy; op = noisy ? 5'd18 - 5'(fin) : 5'd0;
      a_bit = a[k]; b_bit = b[k];
    end
    @(negedge clk);           // after edge 15
    start = 1'b0; op = 5'd0;
    vld_ok = !res_valid && busy;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);         // after edge 16+i
      got[i] = res_bit;
      if (!res_valid) vld_ok = 1'b0;
    end
    check(got == exp[15:0], tag, $sformatf("result op %0d a %h b %h f %0d", code, a, b, fin),
          int'(got), int'(exp[15:0]));
    check(flag == exp[16], tag, $sformatf("flag op %0d a %h b %h f %0d", code, a, b, fin),
          int'(flag), int'(exp[16]));
    @(negedge clk);           // after edge 32
    if (res_valid || busy) vld_ok = 1'b0;
    check(vld_ok, "R1", "valid/busy timing", int'(vld_ok), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] pats [8];
    logic [31:0] lfsr;
    pats[0] = 16'h0000; pats[1] = 16'h0001; pats[2] = 16'h7FFF; pats[3] = 16'h8000;
    pats[4] = 16'hFFFF; pats[5] = 16'h5555; pats[6] = 16'hAAAA; pats[7] = 16'h1234;

    repeat (3) @(negedge clk);
    // R12: reset state
    check(flag == 1'b0 && res_valid == 1'b0 && res_bit == 1'b0 && busy == 1'b0,
          "R12", "reset outputs", int'({flag, res_valid, res_bit, busy}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(flag == 1'b0 && busy == 1'b0, "R12", "after release",
          int'({flag, busy}), 0);

    // two-operand sweep: R2 R3 R5
    for (int c = 0; c <= 8; c++) begin
      if (c == 4 || c == 5) continue;
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int f = 0; f < 2; f++)
            run_op(c, pats[i], pats[j], f[0], 1'b0);
    end
    // one-operand sweep: R4 R5 R6 R7 R8 R9 and undefined codes
    for (int c = 4; c <= 19; c++) begin
      if (c >= 6 && c <= 8) continue;
      if (c == 17 || c == 18) continue;
      for (int i = 0; i < 8; i++)
        for (int f = 0; f < 2; f++)
          run_op(c, pats[i], 16'h0, f[0], 1'b0);
    end
    for (int f = 0; f < 2; f++) run_op(31, 16'hC3A5, 16'h0, f[0], 1'b0);

    // R11: held start with flag-op requests during an operation
    run_op(0, 16'hFFFF, 16'h0001, 1'b0, 1'b1);
    run_op(2, 16'h0000, 16'h0001, 1'b1, 1'b1);
    run_op(14, 16'h0002, 16'h0000, 1'b1, 1'b1);

    // pseudo-random mix over all real opcodes
    lfsr = 32'h1ACE_B00C;
    for (int n = 0; n < 400; n++) begin
      int code;
      lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
      code = int'(lfsr[4:0]) % 17;
      run_op(code, lfsr[15:0], lfsr[31:16], lfsr[7], 1'b0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule